// File: doc/BRIEF.md
# LCD Line Scan Timing Generator

This block produces the refresh timing for a dot-matrix LCD with up to 104 common rows and 132 segment columns. It divides the incoming oscillator clock by a ratio that follows the programmed duty, so that a frame of fewer active rows is refreshed with a longer line period. Each resulting line period is marked by a one-cycle load strobe.

On each line the block advances a line index. From that index it derives a one-hot common scan vector and a display RAM row address. The row address is the line index offset by a programmable start line and wrapped over a 160-row RAM, which gives vertical scrolling through rows that are not on screen. The block latches the 132-bit row word returned by the RAM and holds it for the segment drivers. It also generates the alternation signal `fr`, which flips once per frame or, in n-line inversion mode, every n lines.

For each segment, a 2-bit drive-level code is formed from the latched bit and `fr`. The analog levels themselves are outside this block. The RAM read port is assumed combinational: `ram_row` must reflect `row_addr` within the same cycle.

Top module: `lcdt_scan_timing`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `line_load` is 0, `com_scan` has only bit 0 set, `fr` is 0, `seg_data` is all zero and `row_addr` equals `start_line` modulo 160.
- R2: `duty_code` d in 0..12 selects 8*(d+1) active rows, and codes 13..15 behave as 12. The `line_load` period in clock cycles is 50, 25, 16, 12, 10, 8, 8, 6, 6, 5, 5, 4, 4 for d = 0..12. The first `line_load` after reset comes one full period after reset is released.
- R3: `line_load` is high for exactly one cycle per line. `com_scan` and `fr` change only in a cycle where `line_load` is high.
- R4: `com_scan` always has exactly one bit set. Bit k stands for line index k. Each `line_load` moves it up by one position, and after the last active row, 8*(d+1)-1, it returns to bit 0.
- R5: `row_addr` = (`start_line` + line index) modulo 160 for any `start_line` from 0 to 255, and it follows a change of `start_line` in the same cycle.
- R6: With `ninv` = 0, `fr` toggles only when the scan wraps from the last active row back to row 0.
- R7: With `ninv` = m > 0, `fr` toggles after every m+1 lines and also at each frame wrap. The line count toward the next toggle restarts at every toggle.
- R8: `seg_data` takes the value of `ram_row` at the clock edge that ends a `line_load` cycle, and holds that value at all other times whatever `ram_row` does.
- R9: The bits [2i+1:2i] of `seg_lvl` carry segment i's level code. The codes are: lit with `fr`=1 gives 0 (top supply), lit with `fr`=0 gives 3 (bottom supply), unlit with `fr`=1 gives 1, and unlit with `fr`=0 gives 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_code | input | 4 | Duty select, 8*(code+1) active rows |
| start_line | input | 8 | RAM row shown on common row 0 |
| ninv | input | 7 | n-line inversion setting, n-1; 0 selects frame alternation |
| ram_row | input | 132 | Row word read from display RAM at `row_addr` |
| line_load | output | 1 | One-cycle line strobe, latch load |
| row_addr | output | 8 | Display RAM row address, 0..159 |
| com_scan | output | 104 | One-hot common scan |
| fr | output | 1 | Alternation signal |
| seg_data | output | 132 | Latched row word for the segment drivers |
| seg_lvl | output | 264 | Two-bit drive-level code per segment |

## Verification
The bench measures the strobe period for every duty code, including the clamped codes above 12. A wrong entry in the divide table would show up there as a period that is off by some cycles. It follows the scan through the wrap for an 8-row and a 104-row duty. An off-by-one in the last-row compare would skip or add a common row and move the `fr` flip. The row address is checked with start lines of 150 and 255, where the sum crosses 160 and 320. A missing modulo step would then produce addresses above 159. The n-line inversion is run with n=3 and n=7 against a frame length that is not a multiple of n. The latch is checked while `ram_row` changes in the middle of a line, which exposes a latch that is transparent instead of edge-loaded.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int DUTY_W        = 4;
    localparam int DIV_W         = 6;
    localparam logic [DUTY_W-1:0] DUTY_CODE_MAX = 4'd12;

    // Drive-level code per segment
    typedef enum logic [1:0] {
        LVL_TOP    = 2'd0,
        LVL_HI_MID = 2'd1,
        LVL_LO_MID = 2'd2,
        LVL_BOT    = 2'd3
    } seg_lvl_e;

    // Per-line event produced by the sequencer
    typedef struct packed {
        logic tick;
        logic wrap;
    } line_evt_t;

    function automatic logic [DUTY_W-1:0] clamp_code(input logic [DUTY_W-1:0] c);
        return (c > DUTY_CODE_MAX) ? DUTY_CODE_MAX : c;
    endfunction

    // Oscillator cycles per line, minus one, for a duty code
    function automatic logic [DIV_W-1:0] div_last(input logic [DUTY_W-1:0] c);
        logic [DIV_W-1:0] r;
        case (clamp_code(c))
            4'd0:          r = 6'd50;
            4'd1:          r = 6'd25;
            4'd2:          r = 6'd16;
            4'd3:          r = 6'd12;
            4'd4:          r = 6'd10;
            4'd5, 4'd6:    r = 6'd8;
            4'd7, 4'd8:    r = 6'd6;
            4'd9, 4'd10:   r = 6'd5;
            default:       r = 6'd4;
        endcase
        return r - 6'd1;
    endfunction

    function automatic seg_lvl_e seg_level(input logic on, input logic fr);
        if (on) return fr ? LVL_TOP : LVL_BOT;
        else    return fr ? LVL_HI_MID : LVL_LO_MID;
    endfunction

endpackage

// File: rtl/lcdt_line_div.sv
module lcdt_line_div
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_code,
    output logic              tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    assign last = div_last(duty_code);
    // >= keeps the count bounded when the duty shrinks mid-line
    assign tick = (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lcdt_row_seq.sv
module lcdt_row_seq
    import lcdt_pkg::*;
#(
    parameter int LW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DUTY_W-1:0] duty_code,
    output logic [LW-1:0]     line_idx,
    output line_evt_t         evt
);
    logic [LW-1:0] last_row;

    assign last_row = LW'({clamp_code(duty_code), 3'b111});
    assign evt.tick = tick;
    assign evt.wrap = tick && (line_idx >= last_row);

    always_ff @(posedge clk) begin
        if (rst)           line_idx <= '0;
        else if (evt.wrap) line_idx <= '0;
        else if (tick)     line_idx <= line_idx + 1'b1;
    end
endmodule

// File: rtl/lcdt_fr_gen.sv
module lcdt_fr_gen
    import lcdt_pkg::*;
#(
    parameter int NIW = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  line_evt_t      evt,
    input  logic [NIW-1:0] ninv,
    output logic           fr
);
    logic [NIW-1:0] nctr;
    logic           nline_hit;
    logic           flip;

    assign nline_hit = (ninv != '0) && (nctr >= ninv);
    assign flip      = evt.tick && (evt.wrap || nline_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            nctr <= '0;
            fr   <= 1'b0;
        end else if (flip) begin
            nctr <= '0;
            fr   <= ~fr;
        end else if (evt.tick) begin
            nctr <= nctr + 1'b1;
        end
    end
endmodule

// File: rtl/lcdt_scan_timing.sv
module lcdt_scan_timing
    import lcdt_pkg::*;
#(
    parameter int COM_N    = 104,
    parameter int SEG_N    = 132,
    parameter int RAM_ROWS = 160,
    parameter int ADDR_W   = 8,
    parameter int NIW      = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DUTY_W-1:0]    duty_code,
    input  logic [ADDR_W-1:0]    start_line,
    input  logic [NIW-1:0]       ninv,
    input  logic [SEG_N-1:0]     ram_row,
    output logic                 line_load,
    output logic [ADDR_W-1:0]    row_addr,
    output logic [COM_N-1:0]     com_scan,
    output logic                 fr,
    output logic [SEG_N-1:0]     seg_data,
    output logic [2*SEG_N-1:0]   seg_lvl
);
    localparam int LINE_W = $clog2(COM_N);
    localparam int SUM_W  = ADDR_W + 2;
    localparam logic [SUM_W-1:0] DEPTH1 = SUM_W'(RAM_ROWS);
    localparam logic [SUM_W-1:0] DEPTH2 = SUM_W'(2 * RAM_ROWS);

    logic              tick;
    logic [LINE_W-1:0] line_idx;
    line_evt_t         evt;
    logic [SUM_W-1:0]  row_sum;
    logic [SUM_W-1:0]  row_mod;

    lcdt_line_div u_div (
        .clk       (clk),
        .rst       (rst),
        .duty_code (duty_code),
        .tick      (tick)
    );

    lcdt_row_seq #(.LW(LINE_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .duty_code (duty_code),
        .line_idx  (line_idx),
        .evt       (evt)
    );

    lcdt_fr_gen #(.NIW(NIW)) u_fr (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .ninv (ninv),
        .fr   (fr)
    );

    // Strobe lands in the cycle the line index takes its new value
    always_ff @(posedge clk) begin
        if (rst) line_load <= 1'b0;
        else     line_load <= tick;
    end

    // Scroll offset into the oversized RAM
    assign row_sum = SUM_W'(start_line) + SUM_W'(line_idx);
    always_comb begin
        if (row_sum >= DEPTH2)      row_mod = row_sum - DEPTH2;
        else if (row_sum >= DEPTH1) row_mod = row_sum - DEPTH1;
        else                        row_mod = row_sum;
    end
    assign row_addr = row_mod[ADDR_W-1:0];

    for (genvar i = 0; i < COM_N; i++) begin : g_com
        assign com_scan[i] = (line_idx == LINE_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst)            seg_data <= '0;
        else if (line_load) seg_data <= ram_row;
    end

    for (genvar s = 0; s < SEG_N; s++) begin : g_seg
        assign seg_lvl[2*s +: 2] = seg_level(seg_data[s], fr);
    end
endmodule

// File: rtl/lcdt_scan_chk.sv
module lcdt_scan_chk #(
    parameter int COM_N    = 104,
    parameter int SEG_N    = 132,
    parameter int RAM_ROWS = 160,
    parameter int ADDR_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              line_load,
    input logic [ADDR_W-1:0] row_addr,
    input logic [COM_N-1:0]  com_scan,
    input logic              fr,
    input logic [SEG_N-1:0]  seg_data
);
    assert_load_single_R3: assert property (@(posedge clk) disable iff (rst)
        line_load |=> !line_load);

    assert_com_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !line_load |-> $stable(com_scan));

    assert_com_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(com_scan) == 1);

    assert_row_range_R5: assert property (@(posedge clk) disable iff (rst)
        32'(row_addr) < RAM_ROWS);

    assert_fr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !line_load |-> $stable(fr));

    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !line_load |=> $stable(seg_data));
endmodule

bind lcdt_scan_timing lcdt_scan_chk #(
    .COM_N(COM_N), .SEG_N(SEG_N), .RAM_ROWS(RAM_ROWS), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_load (line_load),
    .row_addr  (row_addr),
    .com_scan  (com_scan),
    .fr        (fr),
    .seg_data  (seg_data)
);

// File: tb/lcdt_scan_timing_test.sv
module lcdt_scan_timing_test;
    localparam int COM_N = 104;
    localparam int SEG_N = 132;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [3:0]         duty_code = 4'd12;
    logic [7:0]         start_line = 8'd0;
    logic [6:0]         ninv = 7'd0;
    logic               noise = 1'b0;
    logic [SEG_N-1:0]   ram_row;
    logic               line_load;
    logic [7:0]         row_addr;
    logic [COM_N-1:0]   com_scan;
    logic               fr;
    logic [SEG_N-1:0]   seg_data;
    logic [2*SEG_N-1:0] seg_lvl;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [SEG_N-1:0] pat(input logic [7:0] r);
        return SEG_N'({9{r, ~r ^ 8'h5A}});
    endfunction

    assign ram_row = pat(row_addr) ^ {SEG_N{noise}};

    lcdt_scan_timing uut (
        .clk(clk), .rst(rst), .duty_code(duty_code), .start_line(start_line),
        .ninv(ninv), .ram_row(ram_row), .line_load(line_load), .row_addr(row_addr),
        .com_scan(com_scan), .fr(fr), .seg_data(seg_data), .seg_lvl(seg_lvl)
    );

    task automatic chk(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic do_reset(input logic [3:0] dc, input logic [7:0] sl, input logic [6:0] ni);
        rst = 1'b1;
        duty_code = dc;
        start_line = sl;
        ninv = ni;
        noise = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_load(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!line_load && n < 200);
    endtask

    function automatic logic [COM_N-1:0] onehot(input int k);
        logic [COM_N-1:0] v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    task automatic t_reset();
        do_reset(4'd12, 8'd37, 7'd0);
        chk(line_load == 1'b0, $sformatf("R1 line_load act=%0b exp=0", line_load));
        chk(com_scan == onehot(0), $sformatf("R1 com_scan act=%h exp=1", com_scan));
        chk(fr == 1'b0, $sformatf("R1 fr act=%0b exp=0", fr));
        chk(seg_data == '0, $sformatf("R1 seg_data act=%h exp=0", seg_data));
        chk(row_addr == 8'd37, $sformatf("R1 row_addr act=%0d exp=37", row_addr));
    endtask

    task automatic t_ratio();
        int codes[14] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 15};
        int per[14]   = '{50, 25, 16, 12, 10, 8, 8, 6, 6, 5, 5, 4, 4, 4};
        int n;
        for (int i = 0; i < 14; i++) begin
            do_reset(4'(codes[i]), 8'd0, 7'd0);
            for (int g = 0; g < 2; g++) begin
                wait_load(n);
                chk(n == per[i], $sformatf("R2 code %0d gap act=%0d exp=%0d", codes[i], n, per[i]));
            end
            @(negedge clk);
            chk(line_load == 1'b0, $sformatf("R3 pulse width code %0d act=%0b exp=0", codes[i], line_load));
        end
    endtask

    task automatic t_scan(input logic [3:0] dc, input int loads);
        int rows = 8 * (int'(dc) + 1);
        int n;
        do_reset(dc, 8'd0, 7'd0);
        for (int j = 1; j <= loads; j++) begin
            wait_load(n);
            if ((j % rows) == 0 || (j % rows) == rows - 1 || j < 3) begin
                chk(com_scan == onehot(j % rows),
                    $sformatf("R4 rows %0d load %0d com act=%h exp bit %0d", rows, j, com_scan, j % rows));
                chk(fr == 1'((j / rows) % 2),
                    $sformatf("R6 rows %0d load %0d fr act=%0b exp=%0d", rows, j, fr, (j / rows) % 2));
            end
        end
    endtask

    task automatic t_rows();
        int n;
        do_reset(4'd12, 8'd150, 7'd0);
        chk(row_addr == 8'd150, $sformatf("R5 row at line 0 act=%0d exp=150", row_addr));
        for (int j = 1; j <= 12; j++) begin
            wait_load(n);
            if (j == 9 || j == 10 || j == 12)
                chk(row_addr == 8'((150 + j) % 160),
                    $sformatf("R5 line %0d row act=%0d exp=%0d", j, row_addr, (150 + j) % 160));
        end
        start_line = 8'd5;
        #1;
        chk(row_addr == 8'd17, $sformatf("R5 scroll change row act=%0d exp=17", row_addr));
        do_reset(4'd12, 8'd255, 7'd0);
        chk(row_addr == 8'd95, $sformatf("R5 start 255 row act=%0d exp=95", row_addr));
        for (int j = 1; j <= 70; j++) wait_load(n);
        chk(row_addr == 8'((255 + 70) % 160),
            $sformatf("R5 start 255 line 70 act=%0d exp=%0d", row_addr, (255 + 70) % 160));
    endtask

    task automatic t_ninv(input logic [3:0] dc, input int m, input int loads);
        int last = 8 * (int'(dc) + 1) - 1;
        int ln = 0, nc = 0, f = 0, n;
        bit wr, tg;
        do_reset(dc, 8'd0, 7'(m));
        for (int j = 1; j <= loads; j++) begin
            wait_load(n);
            wr = (ln == last);
            tg = wr || (nc == m);
            ln = wr ? 0 : ln + 1;
            nc = tg ? 0 : nc + 1;
            f  = tg ? 1 - f : f;
            chk(fr == 1'(f), $sformatf("R7 n=%0d load %0d fr act=%0b exp=%0d", m + 1, j, fr, f));
        end
    endtask

    task automatic lvl_check(input logic expfr, input logic [SEG_N-1:0] d);
        bit ok = 1'b1;
        int bad_i = -1;
        logic [1:0] e;
        for (int i = 0; i < SEG_N; i++) begin
            e = d[i] ? (expfr ? 2'd0 : 2'd3) : (expfr ? 2'd1 : 2'd2);
            if (seg_lvl[2*i +: 2] != e && ok) begin
                ok = 1'b0;
                bad_i = i;
            end
        end
        chk(ok, $sformatf("R9 fr=%0b seg %0d act=%0d exp=%0d", expfr, bad_i,
            (bad_i >= 0) ? seg_lvl[2*bad_i +: 2] : 2'd0,
            (bad_i >= 0) ? (d[bad_i] ? (expfr ? 0 : 3) : (expfr ? 1 : 2)) : 0));
    endtask

    task automatic t_latch();
        logic [7:0] r0, r1;
        int n;
        do_reset(4'd0, 8'd10, 7'd0);
        wait_load(n);
        r0 = row_addr;
        @(negedge clk);
        chk(seg_data == pat(r0), $sformatf("R8 load act=%h exp=%h", seg_data, pat(r0)));
        noise = 1'b1;
        @(negedge clk);
        chk(seg_data == pat(r0), $sformatf("R8 hold mid-line act=%h exp=%h", seg_data, pat(r0)));
        wait_load(n);
        r1 = row_addr;
        chk(seg_data == pat(r0), $sformatf("R8 hold at strobe act=%h exp=%h", seg_data, pat(r0)));
        @(negedge clk);
        chk(seg_data == ~pat(r1), $sformatf("R8 reload act=%h exp=%h", seg_data, ~pat(r1)));
        lvl_check(1'b0, ~pat(r1));
        noise = 1'b0;
        for (int j = 3; j <= 8; j++) wait_load(n);
        r1 = row_addr;
        @(negedge clk);
        chk(fr == 1'b1, $sformatf("R6 fr after wrap act=%0b exp=1", fr));
        lvl_check(1'b1, pat(r1));
    endtask

    initial begin
        t_reset();
        t_ratio();
        t_scan(4'd0, 20);
        t_scan(4'd12, 105);
        t_rows();
        t_ninv(4'd0, 2, 24);
        t_ninv(4'd12, 6, 30);
        t_latch();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule